// File: doc/BRIEF.md
# SD Card Command Line Engine

This block drives the command half of an SD host interface. A host writes a command number, a 32-bit argument and a response selector, then pulses a start strobe. The engine shifts the 48-bit command frame out on the single command wire. The frame carries its CRC7 and is clocked by a card clock that the engine divides down from the system clock. If a reply is expected, the engine releases the wire and waits for the card's start bit. It then captures a 48-bit or a 136-bit reply, checks it and posts the outcome on sticky flags.

The flags stay set until the host writes ones to the matching clear bits. A busy indication covers the whole exchange, and the host treats the command as finished only once that indication drops. The data lines, data buffering and the card power-up sequence belong to other blocks.

Top module: `sdcmd_engine`

## Requirements
- R1: Only `cmd_index[5:0]` enters the frame; any higher index bits have no effect on the transmitted bits.
- R2: The transmitted frame is, MSB first: a 0, a 1, the 6-bit index, the 32-bit argument, CRC7 (polynomial x^7+x^3+1, zero seed) over those 40 bits, then a 1. One bit is driven per card clock, changing as `sd_clk` falls, with `sd_cmd_oe` high only while frame bits are driven.
- R3: `cmd_wait` selects the reply: 01 short (48 bits), 11 long (136 bits), and 00 or 10 no reply.
- R4: With no reply selected, flag bit 0 (sent) rises at the card clock fall that follows the end bit, and neither the CRC-fail nor the timeout flag is raised.
- R5: With a reply selected, exactly one of flag bit 1 (reply good), flag bit 2 (CRC fail) or flag bit 3 (timeout) is raised per command.
- R6: A reply start bit sampled on any of the first 64 card clock rises after the wire is released is accepted. If none arrives by the 64th rise, the timeout flag is raised.
- R7: A short reply sets `resp_data[127:96]` to reply bits [39:8], clears `resp_data[95:0]`, and latches reply bits [45:40] into `resp_index`.
- R8: A long reply sets `resp_data` to reply bits [127:1] followed by a 0, with the CRC taken over reply bits [127:8] and compared with bits [7:1].
- R9: A CRC mismatch or a 0 end bit in a reply raises the CRC-fail flag instead of the reply-good flag.
- R10: `cmd_active` rises the cycle after an accepted start and falls in the cycle the outcome flag is set; a start strobe while active is ignored.
- R11: Flags are sticky across commands. Writing a 1 to `flag_clr[i]` clears flag i only.
- R12: The card clock period is `clk_div + 2` system clocks: high for `N - floor(N/2)` cycles and low for `floor(N/2)`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cmd_start | input | 1 | Start strobe, one cycle |
| cmd_index | input | IDX_IN_W | Command number, low 6 bits used |
| cmd_arg | input | 32 | Command argument |
| cmd_wait | input | 2 | Reply selector |
| clk_div | input | DIV_W | Card clock divider |
| flag_clr | input | 4 | Write-one-to-clear for the flags |
| sd_cmd_in | input | 1 | Command wire as seen from the card side |
| sd_clk | output | 1 | Card clock |
| sd_cmd_out | output | 1 | Command wire drive value |
| sd_cmd_oe | output | 1 | Command wire drive enable |
| cmd_active | output | 1 | Exchange in progress |
| cmd_flags | output | 4 | Sticky flags: 0 sent, 1 reply good, 2 CRC fail, 3 timeout |
| resp_index | output | 6 | Index field of the last short reply |
| resp_data | output | 128 | Captured reply, first word in the top 32 bits |

## Verification
A wrong shift count or CRC state appears on `sd_cmd_out` within the same frame, at the first bad bit, and the bench's card model captures every bit. A receive counter off by one shows in the reply as a shifted `resp_data` word or a false CRC-fail once the exchange completes, about 100 to 300 system clocks after the start. A stuck or miscounted timeout counter moves the accept/timeout boundary between the 64th and 65th card clock. Sweeping across that boundary and across all 64 command numbers exposes it within one command.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

   localparam int CMD_BITS  = 48;
   localparam int LONG_BITS = 136;
   localparam int CRC_W     = 7;
   localparam int FLAG_N    = 4;

   localparam int FLAG_SENT    = 0;
   localparam int FLAG_RESP_OK = 1;
   localparam int FLAG_CRCFAIL = 2;
   localparam int FLAG_TIMEOUT = 3;

   typedef enum logic [1:0] {RESP_NONE, RESP_SHORT, RESP_LONG} resp_kind_t;
   typedef enum logic [2:0] {ST_IDLE, ST_SEND, ST_WAIT, ST_RECV, ST_CHECK} eng_state_t;

   function automatic resp_kind_t decode_wait(input logic [1:0] sel);
      case (sel)
         2'b01:   return RESP_SHORT;
         2'b11:   return RESP_LONG;
         default: return RESP_NONE;
      endcase
   endfunction

   // one serial step of x^7 + x^3 + 1
   function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] c, input logic b);
      logic fb;
      fb = b ^ c[CRC_W-1];
      return {c[CRC_W-2:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
   endfunction

   function automatic logic [CRC_W-1:0] crc7_hdr(input logic [39:0] v);
      logic [CRC_W-1:0] c;
      c = '0;
      for (int i = 39; i >= 0; i--) c = crc7_step(c, v[i]);
      return c;
   endfunction

endpackage

// File: rtl/sdcmd_clkgen.sv
module sdcmd_clkgen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             sd_clk,
   output logic             rise_tick,
   output logic             fall_tick
);
   localparam int CNT_W = DIV_W + 1;

   generate
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
         $error("sdcmd_clkgen: DIV_W out of range");
      end
   endgenerate

   logic [CNT_W-1:0] period, half, cnt;

   assign period    = {1'b0, div} + CNT_W'(2);
   assign half      = period >> 1;
   assign rise_tick = (cnt == half - CNT_W'(1));
   assign fall_tick = (cnt >= period - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         sd_clk <= 1'b0;
      end else begin
         cnt <= fall_tick ? '0 : cnt + CNT_W'(1);
         if (rise_tick)      sd_clk <= 1'b1;
         else if (fall_tick) sd_clk <= 1'b0;
      end
   end

   assert_tick_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_tick && fall_tick));
   assert_clk_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!rise_tick && !fall_tick) |=> $stable(sd_clk));

endmodule

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7 (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       en,
   input  logic       din,
   output logic [6:0] crc
);
   import sdcmd_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   crc <= '0;
      else if (clr) crc <= '0;
      else if (en)  crc <= crc7_step(crc, din);
   end

   assert_crc_seed_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (crc == 7'd0));

endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine #(
   parameter int IDX_IN_W    = 8,
   parameter int DIV_W       = 8,
   parameter int TIMEOUT_CYC = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_start,
   input  logic [IDX_IN_W-1:0] cmd_index,
   input  logic [31:0]         cmd_arg,
   input  logic [1:0]          cmd_wait,
   input  logic [DIV_W-1:0]    clk_div,
   input  logic [3:0]          flag_clr,
   input  logic                sd_cmd_in,
   output logic                sd_clk,
   output logic                sd_cmd_out,
   output logic                sd_cmd_oe,
   output logic                cmd_active,
   output logic [3:0]          cmd_flags,
   output logic [5:0]          resp_index,
   output logic [127:0]        resp_data
);
   import sdcmd_pkg::*;

   localparam int TO_W   = $clog2(TIMEOUT_CYC + 1);
   localparam int BIT_W  = $clog2(CMD_BITS + 1);
   localparam int LEFT_W = $clog2(LONG_BITS);

   generate
      if (IDX_IN_W < 6) begin : g_bad_idx
         $error("sdcmd_engine: IDX_IN_W must be at least 6");
      end
      if (TIMEOUT_CYC < 1) begin : g_bad_to
         $error("sdcmd_engine: TIMEOUT_CYC must be positive");
      end
   endgenerate

   eng_state_t            state;
   resp_kind_t            mode_q;
   logic [CMD_BITS-1:0]   tx_sr;
   logic [BIT_W-1:0]      bit_cnt;
   logic [TO_W-1:0]       to_cnt;
   logic [127:0]          rx_sr;
   logic [LEFT_W-1:0]     rx_left;
   logic [LEFT_W-1:0]     rx_pos;
   logic                  rise_tick, fall_tick;
   logic                  crc_clr, crc_en, reply_ok;
   logic [CRC_W-1:0]      crc_val;
   logic [FLAG_N-1:0]     set_vec;
   logic [39:0]           hdr;

   sdcmd_clkgen #(.DIV_W(DIV_W)) u_clk (
      .clk(clk), .rst_n(rst_n), .div(clk_div),
      .sd_clk(sd_clk), .rise_tick(rise_tick), .fall_tick(fall_tick));

   sdcmd_crc7 u_crc (
      .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en),
      .din(sd_cmd_in), .crc(crc_val));

   assign hdr    = {2'b01, cmd_index[5:0], cmd_arg};
   assign rx_pos = rx_left - LEFT_W'(1);

   always_comb begin
      crc_clr  = (state == ST_WAIT) && rise_tick && !sd_cmd_in;
      crc_en   = (state == ST_RECV) && rise_tick && (rx_pos >= LEFT_W'(8)) &&
                 ((mode_q == RESP_SHORT) || (rx_pos <= LEFT_W'(127)));
      reply_ok = (crc_val == rx_sr[7:1]) && rx_sr[0];
      set_vec  = '0;
      set_vec[FLAG_SENT]    = (state == ST_SEND) && fall_tick && (bit_cnt == '0) &&
                              (mode_q == RESP_NONE);
      set_vec[FLAG_TIMEOUT] = (state == ST_WAIT) && rise_tick && sd_cmd_in &&
                              (to_cnt == TO_W'(TIMEOUT_CYC - 1));
      set_vec[FLAG_RESP_OK] = (state == ST_CHECK) && reply_ok;
      set_vec[FLAG_CRCFAIL] = (state == ST_CHECK) && !reply_ok;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         mode_q     <= RESP_NONE;
         tx_sr      <= '0;
         bit_cnt    <= '0;
         to_cnt     <= '0;
         rx_sr      <= '0;
         rx_left    <= '0;
         sd_cmd_out <= 1'b1;
         sd_cmd_oe  <= 1'b0;
         cmd_active <= 1'b0;
         resp_index <= '0;
         resp_data  <= '0;
      end else begin
         case (state)
            ST_IDLE: if (cmd_start) begin
               tx_sr      <= {hdr, crc7_hdr(hdr), 1'b1};
               bit_cnt    <= BIT_W'(CMD_BITS);
               mode_q     <= decode_wait(cmd_wait);
               cmd_active <= 1'b1;
               state      <= ST_SEND;
            end
            ST_SEND: if (fall_tick) begin
               if (bit_cnt != '0) begin
                  sd_cmd_out <= tx_sr[CMD_BITS-1];
                  sd_cmd_oe  <= 1'b1;
                  tx_sr      <= {tx_sr[CMD_BITS-2:0], 1'b1};
                  bit_cnt    <= bit_cnt - BIT_W'(1);
               end else begin
                  sd_cmd_out <= 1'b1;
                  sd_cmd_oe  <= 1'b0;
                  to_cnt     <= '0;
                  if (mode_q == RESP_NONE) begin
                     cmd_active <= 1'b0;
                     state      <= ST_IDLE;
                  end else begin
                     state <= ST_WAIT;
                  end
               end
            end
            ST_WAIT: if (rise_tick) begin
               if (!sd_cmd_in) begin
                  rx_sr   <= '0;
                  rx_left <= (mode_q == RESP_SHORT) ? LEFT_W'(CMD_BITS - 1)
                                                    : LEFT_W'(LONG_BITS - 1);
                  state   <= ST_RECV;
               end else if (to_cnt == TO_W'(TIMEOUT_CYC - 1)) begin
                  cmd_active <= 1'b0;
                  state      <= ST_IDLE;
               end else begin
                  to_cnt <= to_cnt + TO_W'(1);
               end
            end
            ST_RECV: if (rise_tick) begin
               rx_sr   <= {rx_sr[126:0], sd_cmd_in};
               rx_left <= rx_pos;
               if (rx_left == LEFT_W'(1)) state <= ST_CHECK;
            end
            ST_CHECK: begin
               if (mode_q == RESP_SHORT) begin
                  resp_index <= rx_sr[45:40];
                  resp_data  <= {rx_sr[39:8], 96'd0};
               end else begin
                  resp_data  <= {rx_sr[127:1], 1'b0};
               end
               cmd_active <= 1'b0;
               state      <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // sticky flags, a new event wins over a clear in the same cycle
   generate
      for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cmd_flags[i] <= 1'b0;
            else        cmd_flags[i] <= set_vec[i] | (cmd_flags[i] & ~flag_clr[i]);
         end
      end
      if (IDX_IN_W > 6) begin : g_idx_hi
         logic [IDX_IN_W-7:0] idx_hi;
         assign idx_hi = cmd_index[IDX_IN_W-1:6];
         assert_idx_trunc_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (state == ST_IDLE && cmd_start && idx_hi != '0) |=>
            (tx_sr[45:40] == $past(cmd_index[5:0])));
      end
   endgenerate

   assert_oe_in_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sd_cmd_oe |-> cmd_active);
   assert_noresp_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_active && mode_q == RESP_NONE) |=>
      (!$rose(cmd_flags[FLAG_TIMEOUT]) && !$rose(cmd_flags[FLAG_CRCFAIL])));
   assert_one_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(set_vec));
   assert_wait_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT) |-> (to_cnt < TO_W'(TIMEOUT_CYC)));
   assert_done_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_vec) |=> !cmd_active);
   assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_active && cmd_start) |=> $stable(mode_q));

endmodule

// File: tb/sdcmd_engine_tb.sv
module sdcmd_engine_tb;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cmd_start = 1'b0;
   logic [7:0]   cmd_index = '0;
   logic [31:0]  cmd_arg = '0;
   logic [1:0]   cmd_wait = '0;
   logic [7:0]   clk_div = '0;
   logic [3:0]   flag_clr = '0;
   logic         sd_cmd_in = 1'b1;
   logic         sd_clk, sd_cmd_out, sd_cmd_oe, cmd_active;
   logic [3:0]   cmd_flags;
   logic [5:0]   resp_index;
   logic [127:0] resp_data;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   sdcmd_engine u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_index(cmd_index),
      .cmd_arg(cmd_arg), .cmd_wait(cmd_wait), .clk_div(clk_div),
      .flag_clr(flag_clr), .sd_cmd_in(sd_cmd_in), .sd_clk(sd_clk),
      .sd_cmd_out(sd_cmd_out), .sd_cmd_oe(sd_cmd_oe), .cmd_active(cmd_active),
      .cmd_flags(cmd_flags), .resp_index(resp_index), .resp_data(resp_data));

   task automatic chk(input string req, input logic [135:0] act, input logic [135:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [6:0] crc7_bits(input logic [135:0] v, input int n);
      logic [6:0] c = '0;
      for (int i = n - 1; i >= 0; i--) begin
         logic fb = v[i] ^ c[6];
         c = {c[5:0], 1'b0};
         if (fb) c = c ^ 7'h09;
      end
      return c;
   endfunction

   function automatic logic [47:0] exp_frame(input logic [5:0] idx, input logic [31:0] arg);
      logic [39:0] h = {2'b01, idx, arg};
      return {h, crc7_bits({96'd0, h}, 40), 1'b1};
   endfunction

   function automatic logic [135:0] mk_short(input logic [5:0] ridx, input logic [31:0] st,
                                             input bit bad_crc, input bit bad_end);
      logic [39:0] h = {2'b00, ridx, st};
      logic [6:0]  c = crc7_bits({96'd0, h}, 40) ^ (bad_crc ? 7'h01 : 7'h00);
      return {88'd0, h, c, ~bad_end};
   endfunction

   function automatic logic [135:0] mk_long(input logic [119:0] p, input bit bad_crc);
      logic [6:0] c = crc7_bits({16'd0, p}, 120) ^ (bad_crc ? 7'h10 : 7'h00);
      return {2'b00, 6'h3F, p, c, 1'b1};
   endfunction

   task automatic issue(input logic [7:0] idx, input logic [31:0] arg, input logic [1:0] ws);
      @(negedge clk);
      cmd_index = idx; cmd_arg = arg; cmd_wait = ws; cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
   endtask

   task automatic card_rx(output logic [47:0] fr);
      wait (sd_cmd_oe === 1'b1);
      for (int i = 47; i >= 0; i--) begin
         @(posedge sd_clk);
         fr[i] = sd_cmd_out;
      end
   endtask

   // drives the start bit on the delay-th falling card clock after the end bit
   task automatic card_tx(input logic [135:0] fr, input int nbits, input int delay);
      for (int j = 1; j <= delay; j++) @(negedge sd_clk);
      sd_cmd_in = fr[nbits-1];
      for (int i = nbits - 2; i >= 0; i--) begin
         @(negedge sd_clk);
         sd_cmd_in = fr[i];
      end
      @(negedge sd_clk);
      sd_cmd_in = 1'b1;
   endtask

   task automatic wait_done();
      @(negedge clk);
      while (cmd_active) @(negedge clk);
   endtask

   task automatic do_cmd(input logic [7:0] idx, input logic [31:0] arg, input logic [1:0] ws,
                         input bit respond, input logic [135:0] rfr, input int rbits,
                         input int delay, output logic [47:0] fr);
      logic [47:0] got;
      fork
         issue(idx, arg, ws);
         card_rx(got);
      join
      fr = got;
      if (respond) card_tx(rfr, rbits, delay);
      wait_done();
   endtask

   task automatic clear_flags(input logic [3:0] m);
      @(negedge clk);
      flag_clr = m;
      @(negedge clk);
      flag_clr = '0;
   endtask

   task automatic measure(input int d);
      int h, l, n;
      @(negedge clk);
      clk_div = 8'(d);
      repeat (3) @(posedge sd_clk);
      @(negedge clk);
      h = 0;
      while (sd_clk) begin h++; @(negedge clk); end
      l = 0;
      while (!sd_clk) begin l++; @(negedge clk); end
      n = d + 2;
      chk($sformatf("R12 high cycles div=%0d", d), 136'(h), 136'(n - n / 2));
      chk($sformatf("R12 low cycles div=%0d", d), 136'(l), 136'(n / 2));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [47:0]  fr;
      logic [135:0] rf;
      logic [119:0] pl;

      repeat (4) @(negedge clk);
      chk("R10 reset active", 136'(cmd_active), 136'(0));
      chk("R11 reset flags", 136'(cmd_flags), 136'(0));
      chk("R2 reset oe", 136'(sd_cmd_oe), 136'(0));
      rst_n = 1'b1;

      // R12 divider sweep
      for (int d = 0; d < 8; d++) measure(d);
      @(negedge clk);
      clk_div = '0;
      repeat (4) @(negedge clk);

      // R2 known frame for command 0 with zero argument
      do_cmd(8'd0, 32'd0, 2'b00, 1'b0, '0, 0, 0, fr);
      chk("R2 cmd0 frame", 136'(fr), 136'(48'h400000000095));
      chk("R4 cmd0 sent flag", 136'(cmd_flags), 136'(4'b0001));
      clear_flags(4'hF);
      chk("R11 clear all", 136'(cmd_flags), 136'(0));

      // R2/R4 sweep across every command number
      for (int i = 0; i < 64; i++) begin
         logic [31:0] a = 32'h9E3779B9 * (i + 1);
         do_cmd(8'(i), a, 2'b00, 1'b0, '0, 0, 0, fr);
         chk($sformatf("R2 frame idx=%0d", i), 136'(fr), 136'(exp_frame(6'(i), a)));
         chk($sformatf("R4 flags idx=%0d", i), 136'(cmd_flags), 136'(4'b0001));
         clear_flags(4'hF);
      end

      // R1 upper index bits ignored
      do_cmd(8'hC5, 32'h12345678, 2'b00, 1'b0, '0, 0, 0, fr);
      chk("R1 high index bits dropped", 136'(fr), 136'(exp_frame(6'h05, 32'h12345678)));
      clear_flags(4'hF);

      // R3 selector 10 behaves as no reply
      do_cmd(8'd7, 32'hA5A5A5A5, 2'b10, 1'b0, '0, 0, 0, fr);
      chk("R3 sel 10 gives sent", 136'(cmd_flags), 136'(4'b0001));
      clear_flags(4'hF);

      // R7 short reply, index differing from sent one is still reported
      rf = mk_short(6'd19, 32'hCAFE0123, 1'b0, 1'b0);
      do_cmd(8'd17, 32'h0, 2'b01, 1'b1, rf, 48, 2, fr);
      chk("R5 short good flag", 136'(cmd_flags), 136'(4'b0010));
      chk("R7 short word", 136'(resp_data), 136'({32'hCAFE0123, 96'd0}));
      chk("R7 short index", 136'(resp_index), 136'(6'd19));

      // R11 sticky across a later timeout, then selective clear
      do_cmd(8'd8, 32'h1AA, 2'b01, 1'b0, '0, 0, 0, fr);
      chk("R11 sticky plus timeout", 136'(cmd_flags), 136'(4'b1010));
      clear_flags(4'b1000);
      chk("R11 clear timeout only", 136'(cmd_flags), 136'(4'b0010));
      clear_flags(4'b0010);
      chk("R11 clear good only", 136'(cmd_flags), 136'(4'b0000));

      // R9 bad CRC and bad end bit in short reply
      rf = mk_short(6'd13, 32'h00000900, 1'b1, 1'b0);
      do_cmd(8'd13, 32'h0, 2'b01, 1'b1, rf, 48, 3, fr);
      chk("R9 short crc mismatch", 136'(cmd_flags), 136'(4'b0100));
      clear_flags(4'hF);
      rf = mk_short(6'd13, 32'h00000900, 1'b0, 1'b1);
      do_cmd(8'd13, 32'h0, 2'b01, 1'b1, rf, 48, 3, fr);
      chk("R9 short end bit zero", 136'(cmd_flags), 136'(4'b0100));
      clear_flags(4'hF);

      // R8 long reply
      pl = {32'hDEADBEEF, 32'h01234567, 32'h89ABCDEF, 24'h5A5A5A};
      rf = mk_long(pl, 1'b0);
      do_cmd(8'd2, 32'h0, 2'b11, 1'b1, rf, 136, 5, fr);
      chk("R8 long good flag", 136'(cmd_flags), 136'(4'b0010));
      chk("R8 long data", 136'(resp_data), 136'({pl, crc7_bits({16'd0, pl}, 120), 1'b0}));
      clear_flags(4'hF);
      rf = mk_long(pl, 1'b1);
      do_cmd(8'd9, 32'h0, 2'b11, 1'b1, rf, 136, 2, fr);
      chk("R8 long crc mismatch", 136'(cmd_flags), 136'(4'b0100));
      clear_flags(4'hF);

      // R6 timeout boundary
      rf = mk_short(6'd55, 32'h00000120, 1'b0, 1'b0);
      do_cmd(8'd55, 32'h0, 2'b01, 1'b1, rf, 48, 64, fr);
      chk("R6 start on 64th rise accepted", 136'(cmd_flags), 136'(4'b0010));
      clear_flags(4'hF);
      do_cmd(8'd55, 32'h0, 2'b01, 1'b1, rf, 48, 65, fr);
      chk("R6 start on 65th rise times out", 136'(cmd_flags), 136'(4'b1000));
      chk("R7 index kept after timeout", 136'(resp_index), 136'(6'd55));
      clear_flags(4'hF);

      // R10 start while busy is ignored
      fork
         issue(8'd24, 32'h55AA55AA, 2'b00);
         card_rx(fr);
         begin
            repeat (20) @(negedge clk);
            chk("R10 active mid frame", 136'(cmd_active), 136'(1));
            cmd_index = 8'd40; cmd_arg = 32'hFFFFFFFF; cmd_start = 1'b1;
            @(negedge clk);
            cmd_start = 1'b0;
         end
      join
      wait_done();
      chk("R10 busy start ignored", 136'(fr), 136'(exp_frame(6'd24, 32'h55AA55AA)));
      chk("R10 active low after", 136'(cmd_active), 136'(0));
      repeat (200) @(negedge clk);
      chk("R10 no second frame", 136'(cmd_flags), 136'(4'b0001));
      clear_flags(4'hF);

      // R2 and R7 at a slower card clock
      @(negedge clk);
      clk_div = 8'd3;
      rf = mk_short(6'd41, 32'h00FF00FF, 1'b0, 1'b0);
      do_cmd(8'd41, 32'h40300000, 2'b01, 1'b1, rf, 48, 4, fr);
      chk("R2 frame at div 3", 136'(fr), 136'(exp_frame(6'd41, 32'h40300000)));
      chk("R7 word at div 3", 136'(resp_data), 136'({32'h00FF00FF, 96'd0}));

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule